// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Transmitter

This block turns a stream of stereo audio samples into a biphase-mark line signal of the kind used on consumer and professional digital audio links. Each channel supplies a 24-bit sample word plus validity, user and channel-status bits. The block packs these into a 64-cell subframe. It prefixes the subframe with one of three deliberately non-biphase sync preambles, appends an even-parity bit and drives the result one half-bit cell per clock-enable tick.

Left and right subframes alternate without a break. A frame counter marks the first frame of every 192-frame block with a distinct left-channel preamble. The line level is tracked across cells so that each preamble can be sent in whichever polarity keeps a transition at its first cell. A one-cycle request pulse tells the sample source when to present the next left/right pair. The cell enable is expected to run at twice the audio bit rate.

Top module: `bmc_subframe_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `line_out` is 0 and `sample_req` is 0. The first subframe after reset is a left subframe with the block-start preamble.
- R2: A subframe is 64 cells. Left and right subframes strictly alternate. The cells 0..7 are a preamble: block-start left is 1,1,1,0,1,0,0,0; ordinary left is 1,1,1,0,0,0,1,0; right is 1,1,1,0,0,1,0,0 (cell 0 listed first), or the bitwise complement of the chosen sequence.
- R3: The first preamble cell always differs from the cell driven just before it. The complemented form is used when the previous cell was 1.
- R4: Cells 8..63 carry 28 payload bits, two cells per bit. The first cell of each bit differs from the previous cell. A 0 bit has two equal cells and a 1 bit has two unequal cells.
- R5: Payload order, first sent to last: sample word bits 0 to 23 (LSB first), then validity, then user, then channel-status, then parity.
- R6: The parity bit makes the count of ones among the 28 payload bits even.
- R7: The block-start preamble is used on the left subframe of frame 0 and of every 192nd frame after it. All other left subframes use the ordinary left preamble.
- R8: A left subframe carries the left-channel inputs and a right subframe carries the right-channel inputs. Both are sampled at the tick that emits the subframe's cell 0.
- R9: `sample_req` is high for exactly one clock, the clock after the tick that emits cell 0 of a right subframe, and never at any other time.
- R10: With `cell_en` low, `line_out` holds and the cell position does not advance. With `cell_en` held high, one cell is emitted per clock, with no gap between subframes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | Cell-rate enable, one tick per half-bit cell |
| left_sample | input | 24 | Left-channel sample word |
| left_valid | input | 1 | Left validity bit |
| left_user | input | 1 | Left user bit |
| left_status | input | 1 | Left channel-status bit |
| right_sample | input | 24 | Right-channel sample word |
| right_valid | input | 1 | Right validity bit |
| right_user | input | 1 | Right user bit |
| right_status | input | 1 | Right channel-status bit |
| line_out | output | 1 | Registered biphase-mark line output |
| sample_req | output | 1 | One-cycle request for the next sample pair |

## Verification
The in-line assertions check, on every cycle, the cell-level invariants: the line holds while the enable is low, and there is a transition at each preamble start and each bit boundary. They also check the one-cycle shape of the request, the channel swap at the end of each subframe, the range of the frame counter and the even parity of the latched payload. Only the bench's scenarios can show the content of the stream: the exact preamble sequences, the placement of the block-start preamble across a full 192-frame wrap, the mapping of left and right inputs into their subframes, and the restart as a block start after a reset in mid-stream.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int PRE_CELLS = 8;
    localparam int PAY_BITS  = SAMPLE_W + 4;
    localparam int SUB_CELLS = PRE_CELLS + 2 * PAY_BITS;
    localparam int CELL_W    = $clog2(SUB_CELLS);
    localparam int BITPOS_W  = $clog2(PAY_BITS);

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_LEFT  = 2'd1,
        PRE_RIGHT = 2'd2
    } pre_kind_e;

    typedef struct packed {
        logic                status;
        logic                user;
        logic                valid;
        logic [SAMPLE_W-1:0] smp;
    } chan_word_t;

    // bit 0 is the first payload bit on the line
    typedef struct packed {
        logic                parity;
        logic                status;
        logic                user;
        logic                valid;
        logic [SAMPLE_W-1:0] smp;
    } payload_t;

    // bit i of the result is preamble cell i
    function automatic logic [PRE_CELLS-1:0] pre_pattern(input pre_kind_e kind);
        logic [PRE_CELLS-1:0] pat;
        case (kind)
            PRE_BLOCK: pat = 8'b0001_0111;
            PRE_LEFT:  pat = 8'b0100_0111;
            PRE_RIGHT: pat = 8'b0010_0111;
            default:   pat = 8'b0100_0111;
        endcase
        return pat;
    endfunction

    function automatic payload_t pack_payload(input chan_word_t w);
        payload_t p;
        p.smp    = w.smp;
        p.valid  = w.valid;
        p.user   = w.user;
        p.status = w.status;
        p.parity = ^w;
        return p;
    endfunction

endpackage

// File: rtl/bmc_tx_seq.sv
module bmc_tx_seq
    import bmc_tx_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_en,
    output logic [CELL_W-1:0] cell_idx,
    output logic              chan_b,
    output logic              block_start,
    output logic              sample_req
);

    localparam int FRAME_W = $clog2(FRAMES_PER_BLOCK);
    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAMES_PER_BLOCK - 1);
    localparam logic [CELL_W-1:0]  CELL_LAST  = CELL_W'(SUB_CELLS - 1);

    logic [FRAME_W-1:0] frame_q;
    logic               sub_end;

    assign sub_end     = (cell_idx == CELL_LAST);
    assign block_start = (frame_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_idx   <= '0;
            chan_b     <= 1'b0;
            frame_q    <= '0;
            sample_req <= 1'b0;
        end else begin
            sample_req <= cell_en && chan_b && (cell_idx == '0);
            if (cell_en) begin
                cell_idx <= sub_end ? '0 : cell_idx + 1'b1;
                if (sub_end) begin
                    chan_b <= ~chan_b;
                    if (chan_b) begin
                        frame_q <= (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
                    end
                end
            end
        end
    end

    p_req_single_r9: assert property (@(posedge clk) disable iff (rst)
        sample_req |=> !sample_req);

    p_req_after_right_r9: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (chan_b && cell_idx == CELL_W'(1)));

    p_chan_swap_r2: assert property (@(posedge clk) disable iff (rst)
        (cell_en && sub_end) |=> (chan_b != $past(chan_b)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cell_en |=> $stable(cell_idx));

    p_frame_range_r7: assert property (@(posedge clk) disable iff (rst)
        frame_q <= FRAME_LAST);

endmodule

// File: rtl/bmc_tx_load.sv
module bmc_tx_load
    import bmc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       chan_b,
    input  chan_word_t left_w,
    input  chan_word_t right_w,
    output payload_t   pay_q
);

    chan_word_t sel_w;

    assign sel_w = chan_b ? right_w : left_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q <= '0;
        end else if (load) begin
            pay_q <= pack_payload(sel_w);
        end
    end

    p_even_parity_r6: assert property (@(posedge clk) disable iff (rst)
        ($countones(pay_q) % 2) == 0);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pay_q));

endmodule

// File: rtl/bmc_tx_enc.sv
module bmc_tx_enc
    import bmc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_en,
    input  logic [CELL_W-1:0] cell_idx,
    input  logic              chan_b,
    input  logic              block_start,
    input  payload_t          pay_q,
    output logic              line
);

    localparam int PAD_W = 1 << BITPOS_W;

    pre_kind_e            kind;
    logic [PRE_CELLS-1:0] pat;
    logic                 inv_q;
    logic                 inv;
    logic                 in_pre;
    logic [CELL_W-1:0]    rel;
    logic [BITPOS_W-1:0]  bit_pos;
    logic [PAD_W-1:0]     pay_pad;
    logic                 cur_bit;
    logic                 next_cell;

    always_comb begin
        if (chan_b)           kind = PRE_RIGHT;
        else if (block_start) kind = PRE_BLOCK;
        else                  kind = PRE_LEFT;
    end

    assign pat     = pre_pattern(kind);
    assign in_pre  = (cell_idx < CELL_W'(PRE_CELLS));
    assign inv     = (cell_idx == '0) ? line : inv_q;
    assign rel     = cell_idx - CELL_W'(PRE_CELLS);
    assign bit_pos = rel[CELL_W-1:1];
    assign pay_pad = PAD_W'(pay_q);
    assign cur_bit = pay_pad[bit_pos];

    always_comb begin
        if (in_pre) begin
            next_cell = pat[cell_idx[2:0]] ^ inv;
        end else if (!cell_idx[0]) begin
            next_cell = ~line;
        end else begin
            next_cell = cur_bit ? ~line : line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line  <= 1'b0;
            inv_q <= 1'b0;
        end else if (cell_en) begin
            line <= next_cell;
            if (cell_idx == '0) begin
                inv_q <= line;
            end
        end
    end

    p_line_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cell_en |=> $stable(line));

    p_pre_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cell_idx == '0) |=> (line != $past(line)));

    p_bit_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (cell_en && !in_pre && !cell_idx[0]) |=> (line != $past(line)));

endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
    import bmc_tx_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cell_en,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic                left_valid,
    input  logic                left_user,
    input  logic                left_status,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                right_valid,
    input  logic                right_user,
    input  logic                right_status,
    output logic                line_out,
    output logic                sample_req
);

    logic [CELL_W-1:0] cell_idx;
    logic              chan_b;
    logic              block_start;
    chan_word_t        left_w;
    chan_word_t        right_w;
    payload_t          pay_q;

    assign left_w  = '{status: left_status,  user: left_user,  valid: left_valid,  smp: left_sample};
    assign right_w = '{status: right_status, user: right_user, valid: right_valid, smp: right_sample};

    bmc_tx_seq #(
        .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cell_en    (cell_en),
        .cell_idx   (cell_idx),
        .chan_b     (chan_b),
        .block_start(block_start),
        .sample_req (sample_req)
    );

    bmc_tx_load u_load (
        .clk    (clk),
        .rst    (rst),
        .load   (cell_en && cell_idx == '0),
        .chan_b (chan_b),
        .left_w (left_w),
        .right_w(right_w),
        .pay_q  (pay_q)
    );

    bmc_tx_enc u_enc (
        .clk        (clk),
        .rst        (rst),
        .cell_en    (cell_en),
        .cell_idx   (cell_idx),
        .chan_b     (chan_b),
        .block_start(block_start),
        .pay_q      (pay_q),
        .line       (line_out)
    );

    p_reset_low_r1: assert property (@(posedge clk)
        $past(rst) |-> (!line_out && !sample_req));

endmodule

// File: tb/sim_bmc_subframe_tx.sv
`timescale 1ns/1ps
module sim_bmc_subframe_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cell_en = 1'b0;
    logic [23:0] left_sample = '0, right_sample = '0;
    logic        left_valid = 0, left_user = 0, left_status = 0;
    logic        right_valid = 0, right_user = 0, right_status = 0;
    logic        line_out, sample_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bmc_subframe_tx u0 (
        .clk(clk), .rst(rst), .cell_en(cell_en),
        .left_sample(left_sample), .left_valid(left_valid),
        .left_user(left_user), .left_status(left_status),
        .right_sample(right_sample), .right_valid(right_valid),
        .right_user(right_user), .right_status(right_status),
        .line_out(line_out), .sample_req(sample_req)
    );

    // {left sample, left v,u,c, right sample, right v,u,c}
    localparam logic [53:0] VEC [8] = '{
        {24'h000000, 3'b000, 24'hFFFFFF, 3'b111},
        {24'hA5A5A5, 3'b100, 24'h5A5A5A, 3'b010},
        {24'h123456, 3'b001, 24'h654321, 3'b110},
        {24'h800001, 3'b011, 24'h7FFFFE, 3'b101},
        {24'hFFFFFF, 3'b111, 24'h000000, 3'b000},
        {24'h000001, 3'b000, 24'h800000, 3'b001},
        {24'hC0FFEE, 3'b101, 24'h0BADF0, 3'b011},
        {24'h3C3C3C, 3'b010, 24'hF0F0F0, 3'b100}
    };

    // preamble cells, bit i = cell i
    localparam logic [7:0] PAT_BLK = 8'b0001_0111;
    localparam logic [7:0] PAT_A   = 8'b0100_0111;
    localparam logic [7:0] PAT_B   = 8'b0010_0111;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] build_pay(input logic [23:0] s, input logic [2:0] vuc);
        logic par;
        par = ^{s, vuc};
        return {par, vuc[0], vuc[1], vuc[2], s};
    endfunction

    function automatic logic [63:0] model_sub(input logic [7:0] pat, input logic [27:0] pay, input logic prev);
        logic [63:0] r;
        logic lv, a, b;
        lv = prev;
        for (int i = 0; i < 8; i++) begin
            r[i] = pat[i] ^ prev;
            lv = r[i];
        end
        for (int k = 0; k < 28; k++) begin
            a = ~lv;
            b = pay[k] ? ~a : a;
            r[8 + 2*k] = a;
            r[9 + 2*k] = b;
            lv = b;
        end
        return r;
    endfunction

    task automatic apply_vec(input int idx);
        {left_sample, left_valid, left_user, left_status,
         right_sample, right_valid, right_user, right_status} = VEC[idx];
    endtask

    // collect 64 cells; gap=1 inserts one disabled clock before each cell
    task automatic grab(input bit gap, input int next_idx, output logic [63:0] got,
                        output int reqs, output int req_pos, output int hold_bad);
        logic prev;
        reqs = 0; req_pos = -1; hold_bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (gap) begin
                prev = line_out;
                cell_en = 1'b0;
                @(posedge clk); #1;
                if (line_out !== prev || sample_req) hold_bad++;
                cell_en = 1'b1;
            end
            @(posedge clk); #1;
            got[i] = line_out;
            if (sample_req) begin
                reqs++;
                req_pos = i;
                if (next_idx >= 0) apply_vec(next_idx);
            end
        end
    endtask

    function automatic int pay_ones(input logic [63:0] c);
        int n = 0;
        for (int k = 0; k < 28; k++) n += int'(c[8 + 2*k] ^ c[9 + 2*k]);
        return n;
    endfunction

    function automatic bit edges_ok(input logic [63:0] c, input logic prev);
        bit ok = (c[0] != prev);
        for (int k = 0; k < 28; k++) if (c[8 + 2*k] == c[7 + 2*k]) ok = 0;
        return ok;
    endfunction

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", wd);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, exp;
        logic        lvl;
        int          reqs, rpos, hbad, vi;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(line_out === 1'b0 && sample_req === 1'b0, "R1 reset outputs",
              {62'd0, line_out, sample_req}, 64'd0);
        rst = 1'b0;
        // R10: disabled enable keeps the line idle
        repeat (3) @(posedge clk);
        #1;
        check(line_out === 1'b0, "R10 idle hold", {63'd0, line_out}, 64'd0);

        apply_vec(0);
        cell_en = 1'b1;
        lvl = 1'b0;
        for (int f = 0; f < 194; f++) begin
            vi = f % 8;
            // left subframe: R2 R5 R7 R8
            grab(0, -1, got, reqs, rpos, hbad);
            exp = model_sub((f % 192 == 0) ? PAT_BLK : PAT_A,
                            build_pay(VEC[vi][53:30], VEC[vi][29:27]), lvl);
            check(got === exp, $sformatf("R2/R5/R7/R8 left frame %0d", f), got, exp);
            check(edges_ok(got, lvl), "R3/R4 left transitions", got, exp);
            check(pay_ones(got) % 2 == 0, "R6 left parity", 64'(pay_ones(got)), 64'd0);
            check(reqs == 0, "R9 no request on left", 64'(reqs), 64'd0);
            lvl = exp[63];
            // right subframe
            grab(0, (f + 1) % 8, got, reqs, rpos, hbad);
            exp = model_sub(PAT_B, build_pay(VEC[vi][26:3], VEC[vi][2:0]), lvl);
            check(got === exp, $sformatf("R2/R5/R8 right frame %0d", f), got, exp);
            check(edges_ok(got, lvl), "R3/R4 right transitions", got, exp);
            check(pay_ones(got) % 2 == 0, "R6 right parity", 64'(pay_ones(got)), 64'd0);
            check(reqs == 1 && rpos == 0, "R9 request pulse", 64'(rpos), 64'd0);
            lvl = exp[63];
        end

        // R1: reset mid-stream, then restart as block start
        #0 rst = 1'b1;
        apply_vec(3);
        @(posedge clk); #1;
        check(line_out === 1'b0 && sample_req === 1'b0, "R1 mid-stream reset",
              {62'd0, line_out, sample_req}, 64'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        // R10: enable with gaps, line holds on disabled clocks
        grab(1, -1, got, reqs, rpos, hbad);
        exp = model_sub(PAT_BLK, build_pay(VEC[3][53:30], VEC[3][29:27]), 1'b0);
        check(got === exp, "R1/R7 block start after reset", got, exp);
        check(hbad == 0, "R10 hold while disabled", 64'(hbad), 64'd0);
        lvl = exp[63];
        grab(1, 4, got, reqs, rpos, hbad);
        exp = model_sub(PAT_B, build_pay(VEC[3][26:3], VEC[3][2:0]), lvl);
        check(got === exp, "R8/R10 right with gaps", got, exp);
        check(hbad == 0 && reqs == 1, "R9/R10 gap request", 64'(reqs), 64'd1);
        lvl = exp[63];
        cell_en = 1'b1;
        grab(0, -1, got, reqs, rpos, hbad);
        exp = model_sub(PAT_A, build_pay(VEC[4][53:30], VEC[4][29:27]), lvl);
        check(got === exp, "R7 ordinary left after block start", got, exp);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule